// File: doc/BRIEF.md
# Display-Fetch Shadow Fetcher

This block sits next to a host computer's memory bus and watches for the cycles in which the display DMA controller reads screen memory. A cycle counts as a screen read when the controller holds the processor halted and the cycle is not a memory refresh. On each such cycle the block takes the host address and reads the matching pair of bytes from a private shadow RAM. The shadow RAM is twice as wide as the host screen area and uses the same layout. The two bytes go to a downstream pixel stage, which can then draw more bits per pixel than the host display delivers.

The host CPU cycle is made of a low phase and a high phase of the phase input `phi2`. Each phase lasts at least three `clk` cycles. Halt, refresh and the address are sampled on the single `clk` edge at which `phi2` is first seen high, which ends the low phase. The first shadow read uses the host address shifted up one bit with bit 0 clear. The second read follows half a CPU cycle later, at the edge where `phi2` is first seen low, with bit 0 set. The shadow RAM returns its data on `mem_rdata` one clock after it samples the strobe. The block samples that data two edges after it raised `mem_rd`.

A page filter can ignore screen reads that fall in an even-numbered 8 KB page of the 16 KB host window. The display program, character sets and sprite tables can then live in those pages without wasting any shadow traffic. The output is a one-cycle valid pulse with no back-pressure, because the snooped bus cannot be stalled. The consumer must take `out_lo`/`out_hi` in the cycle `out_valid` is high. The bytes stay on the pins until the next pair arrives.

Top module: `shadow_fetch_snoop`

## Requirements
- R1: A screen read is taken only when, at the edge where `phi2` is first sampled high, `dma_halt` is 1 and `refresh_cyc` is 0; all other combinations produce no `mem_rd` strobe.
- R2: The first shadow read of a taken cycle drives `mem_addr` = {host_addr[13:0], 1'b0}, with its strobe high in the clock right after the sampling edge.
- R3: The second shadow read drives `mem_addr` = {host_addr[13:0], 1'b1}, with its strobe high in the clock right after the edge where `phi2` is first sampled low, which is exactly one phase length after the first strobe.
- R4: With `page_en` = 1, a read whose host_addr[13] is 0 (even 8 KB page) is ignored: no strobe, no valid pulse.
- R5: With `page_en` = 0, reads in both 8 KB pages are taken.
- R6: `out_valid` is high for exactly one clock, two clocks after the second strobe; in that cycle `out_lo` holds the byte read at the even address and `out_hi` the byte read at the odd address.
- R7: Refresh cycles, non-halt cycles and ignored reads leave `out_lo`, `out_hi` and `out_valid` unchanged.
- R8: Halt and refresh are looked at only on the sampling edge; pulses on them at any other time during the host cycle do not change the outcome.
- R9: During and right after reset, `mem_rd` and `out_valid` are 0 and `out_lo`, `out_hi` and `mem_addr` are all zero.
- R10: Each shadow read strobe is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least three cycles per host phase |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Host CPU phase level, synchronous to clk; high is the second phase |
| dma_halt | input | 1 | High while the display DMA controller owns the bus |
| refresh_cyc | input | 1 | High when the current bus cycle is a memory refresh |
| host_addr | input | 14 | Low bits of the host address bus |
| page_en | input | 1 | 1 = ignore reads in even 8 KB pages |
| mem_rdata | input | 8 | Shadow RAM read data, valid one clock after it samples the strobe |
| mem_addr | output | 15 | Shadow RAM address |
| mem_rd | output | 1 | Shadow RAM read strobe |
| out_lo | output | 8 | Byte read at the even shadow address |
| out_hi | output | 8 | Byte read at the odd shadow address |
| out_valid | output | 1 | One-cycle pulse: a new byte pair is on out_lo/out_hi |

## Verification
The bench keeps the default widths: a 14-bit host address, 8-bit data and the page filter built in. It runs each host phase for three clocks, the shortest legal phase, so the second read and the valid pulse land as close to the next host cycle as the timing allows. A stride sweep covers the whole 16 KB window, crossing every halt/refresh combination with both filter settings. The shadow RAM model returns a byte computed from the address, so every strobe, address and byte pair can be predicted arithmetically. Directed host cycles toggle halt and refresh away from the sampling edge to show that only that edge counts.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_RD0  = 3'd1,
    SQ_CAP0 = 3'd2,
    SQ_WAIT = 3'd3,
    SQ_RD1  = 3'd4,
    SQ_CAP1 = 3'd5
  } sq_state_t;

endpackage

// File: rtl/sfs_phase.sv
// Finds the clock edges that close each host phase.
module sfs_phase (
  input  logic clk,
  input  logic phi2,
  output logic phi2_rise,
  output logic phi2_fall
);
  logic phi2_q;

  always_ff @(posedge clk) begin
    phi2_q <= phi2;
  end

  assign phi2_rise = phi2 & ~phi2_q;
  assign phi2_fall = ~phi2 & phi2_q;
endmodule

// File: rtl/sfs_qualify.sv
// Decides whether the sampled bus cycle is a wanted screen read.
module sfs_qualify #(
  parameter int HAW         = 14,
  parameter bit PAGE_FILTER = 1'b1
) (
  input  logic           phi2_rise,
  input  logic           dma_halt,
  input  logic           refresh_cyc,
  input  logic           page_en,
  input  logic [HAW-1:0] host_addr,
  output logic           take
);
  logic dma_read;
  logic page_ok;

  assign dma_read = phi2_rise & dma_halt & ~refresh_cyc;

  generate
    if (PAGE_FILTER) begin : g_filter
      // the top address bit picks the odd or even 8 KB page
      assign page_ok = ~page_en | host_addr[HAW-1];
    end else begin : g_nofilter
      logic unused_bits;
      assign unused_bits = page_en ^ (^host_addr);
      assign page_ok     = 1'b1 | unused_bits;
    end
  endgenerate

  assign take = dma_read & page_ok;
endmodule

// File: rtl/sfs_seq.sv
// Issues the two shadow reads for a taken cycle and assembles the pair.
module sfs_seq
  import sfs_pkg::*;
#(
  parameter int HAW = 14,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           phi2_fall,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic [HAW:0]   mem_addr,
  output logic           mem_rd,
  output logic [DW-1:0]  out_lo,
  output logic [DW-1:0]  out_hi,
  output logic           out_valid,
  output logic           idle
);
  sq_state_t      st;
  logic [HAW-1:0] base;
  logic [DW-1:0]  lo_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      base      <= '0;
      lo_hold   <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
      out_valid <= 1'b0;
    end else begin
      mem_rd    <= 1'b0;
      out_valid <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (take) begin
            base     <= host_addr;
            mem_addr <= {host_addr, 1'b0};
            mem_rd   <= 1'b1;
            st       <= SQ_RD0;
          end
        end
        SQ_RD0:  st <= SQ_CAP0;
        SQ_CAP0: begin
          lo_hold <= mem_rdata;
          st      <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (phi2_fall) begin
            mem_addr <= {base, 1'b1};
            mem_rd   <= 1'b1;
            st       <= SQ_RD1;
          end
        end
        SQ_RD1:  st <= SQ_CAP1;
        SQ_CAP1: begin
          out_lo    <= lo_hold;
          out_hi    <= mem_rdata;
          out_valid <= 1'b1;
          st        <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign idle = (st == SQ_IDLE);
endmodule

// File: rtl/shadow_fetch_snoop.sv
module shadow_fetch_snoop #(
  parameter int HOST_AW     = 14,
  parameter int DATA_W      = 8,
  parameter bit PAGE_FILTER = 1'b1,
  localparam int SHADOW_AW  = HOST_AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phi2,
  input  logic                 dma_halt,
  input  logic                 refresh_cyc,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic                 page_en,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [SHADOW_AW-1:0] mem_addr,
  output logic                 mem_rd,
  output logic [DATA_W-1:0]    out_lo,
  output logic [DATA_W-1:0]    out_hi,
  output logic                 out_valid
);
  logic phi2_rise;
  logic phi2_fall;
  logic take_raw;
  logic seq_idle;

  sfs_phase u_phase (
    .clk       (clk),
    .phi2      (phi2),
    .phi2_rise (phi2_rise),
    .phi2_fall (phi2_fall)
  );

  sfs_qualify #(
    .HAW         (HOST_AW),
    .PAGE_FILTER (PAGE_FILTER)
  ) u_qual (
    .phi2_rise   (phi2_rise),
    .dma_halt    (dma_halt),
    .refresh_cyc (refresh_cyc),
    .page_en     (page_en),
    .host_addr   (host_addr),
    .take        (take_raw)
  );

  sfs_seq #(
    .HAW (HOST_AW),
    .DW  (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_raw),
    .phi2_fall (phi2_fall),
    .host_addr (host_addr),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .out_lo    (out_lo),
    .out_hi    (out_hi),
    .out_valid (out_valid),
    .idle      (seq_idle)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int HAW         = 14,
  parameter int DW          = 8,
  parameter bit PAGE_FILTER = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           phi2,
  input logic           dma_halt,
  input logic           refresh_cyc,
  input logic [HAW-1:0] host_addr,
  input logic           page_en,
  input logic [HAW:0]   mem_addr,
  input logic           mem_rd,
  input logic [DW-1:0]  out_lo,
  input logic [DW-1:0]  out_hi,
  input logic           out_valid,
  input logic           seq_idle
);
  // R1, R2: a wanted cycle starts the even read at the shifted address
  p_take_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi2) && dma_halt && !refresh_cyc && seq_idle &&
     (!PAGE_FILTER || !page_en || host_addr[HAW-1]))
    |=> (mem_rd && mem_addr == {$past(host_addr), 1'b0}));

  // R1, R8: no halt or a refresh at the sampling edge gives no strobe
  p_no_dma_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi2) && (!dma_halt || refresh_cyc)) |=> !mem_rd);

  // R4: even page ignored while the filter is on
  p_even_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi2) && PAGE_FILTER && page_en && !host_addr[HAW-1]) |=> !mem_rd);

  // R3: the odd read follows the edge that ends the high phase
  p_odd_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[0]) |-> ($past(phi2, 2) && !$past(phi2)));

  // R8: the even read follows the edge that ends the low phase
  p_even_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_addr[0]) |-> (!$past(phi2, 2) && $past(phi2)));

  // R10: strobe lasts one clock
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6: valid lasts one clock and comes two clocks after an odd read
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_valid_after_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(mem_rd, 2) && $past(mem_addr[0], 2)));

  // R7: outputs only move with a valid pulse
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_lo) && $stable(out_hi)));
endmodule

bind shadow_fetch_snoop sfs_checker #(
  .HAW         (HOST_AW),
  .DW          (DATA_W),
  .PAGE_FILTER (PAGE_FILTER)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phi2        (phi2),
  .dma_halt    (dma_halt),
  .refresh_cyc (refresh_cyc),
  .host_addr   (host_addr),
  .page_en     (page_en),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd),
  .out_lo      (out_lo),
  .out_hi      (out_hi),
  .out_valid   (out_valid),
  .seq_idle    (seq_idle)
);

// File: tb/shadow_fetch_snoop_test.sv
`timescale 1ns/1ps
module shadow_fetch_snoop_test;
  localparam int PH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0;
  logic        dma_halt = 1'b0;
  logic        refresh_cyc = 1'b0;
  logic [13:0] host_addr = '0;
  logic        page_en = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [14:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  out_lo, out_hi;
  logic        out_valid;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  shadow_fetch_snoop uut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .dma_halt(dma_halt),
    .refresh_cyc(refresh_cyc), .host_addr(host_addr), .page_en(page_en),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .out_lo(out_lo), .out_hi(out_hi), .out_valid(out_valid)
  );

  function automatic logic [7:0] shadow_byte(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5b;
  endfunction

  // shadow RAM model: one clock of read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= shadow_byte(mem_addr);
  end

  // port monitor, sampled on the falling edge
  int          cyc = 0;
  int          nrd = 0;
  int          nval = 0;
  logic [14:0] raddr [4];
  int          rcyc  [4];
  int          vcyc = 0;
  int          wide_strobe = 0;
  logic        rd_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mem_rd) begin
      raddr[nrd % 4] = mem_addr;
      rcyc[nrd % 4]  = cyc;
      nrd = nrd + 1;
      if (rd_prev) wide_strobe = wide_strobe + 1;
    end
    rd_prev = mem_rd;
    if (out_valid) begin
      nval = nval + 1;
      vcyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one host CPU cycle; glitch flips halt/refresh away from the sample edge
  task automatic host_cycle(input bit h, input bit r, input logic [13:0] a,
                            input bit glitch);
    int          rd0, val0, wide0;
    logic [7:0]  lo0, hi0;
    bit          want;
    logic [14:0] ea;
    @(negedge clk);
    rd0 = nrd; val0 = nval; wide0 = wide_strobe;
    lo0 = out_lo; hi0 = out_hi;
    host_addr = a;
    phi2 = 1'b0;
    dma_halt = glitch ? ~h : h;
    refresh_cyc = glitch ? ~r : r;
    repeat (PH - 1) @(negedge clk);
    @(negedge clk);
    phi2 = 1'b1;
    dma_halt = h;
    refresh_cyc = r;
    @(negedge clk);
    if (glitch) begin dma_halt = ~h; refresh_cyc = ~r; end
    repeat (PH - 1) @(negedge clk);
    phi2 = 1'b0;
    dma_halt = 1'b0;
    refresh_cyc = 1'b0;
    repeat (6) @(negedge clk);

    want = h && !r && (!page_en || a[13]);
    ea = {a, 1'b0};
    if (want) begin
      check(nrd - rd0 == 2, glitch ? "R8" : "R1", "read count", nrd - rd0, 2);
      check(raddr[rd0 % 4] == ea, "R2", "even addr", int'(raddr[rd0 % 4]), int'(ea));
      check(raddr[(rd0 + 1) % 4] == (ea | 15'd1), "R3", "odd addr",
            int'(raddr[(rd0 + 1) % 4]), int'(ea | 15'd1));
      check(rcyc[(rd0 + 1) % 4] - rcyc[rd0 % 4] == PH, "R3", "read spacing",
            rcyc[(rd0 + 1) % 4] - rcyc[rd0 % 4], PH);
      check(nval - val0 == 1, "R6", "valid count", nval - val0, 1);
      check(vcyc - rcyc[(rd0 + 1) % 4] == 2, "R6", "valid delay",
            vcyc - rcyc[(rd0 + 1) % 4], 2);
      check(out_lo == shadow_byte(ea), "R6", "lo byte", out_lo, shadow_byte(ea));
      check(out_hi == shadow_byte(ea | 15'd1), "R6", "hi byte", out_hi,
            shadow_byte(ea | 15'd1));
      if (!page_en && !a[13])
        check(1'b1, "R5", "even page taken", 0, 0);
    end else begin
      check(nrd == rd0, (page_en && !a[13] && h && !r) ? "R4" :
            (glitch ? "R8" : "R1"), "no read", nrd - rd0, 0);
      check(nval == val0 && out_lo == lo0 && out_hi == hi0, "R7", "outputs held",
            {out_hi, out_lo}, {hi0, lo0});
    end
    check(wide_strobe == wide0, "R10", "strobe width", wide_strobe - wide0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R9: reset state
    check(mem_rd == 1'b0 && out_valid == 1'b0, "R9", "reset strobes",
          {mem_rd, out_valid}, 0);
    check(out_lo == 8'h0 && out_hi == 8'h0 && mem_addr == 15'h0, "R9",
          "reset data", {out_hi, out_lo}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_rd == 1'b0 && out_valid == 1'b0, "R9", "after reset",
          {mem_rd, out_valid}, 0);

    // stride sweep over the 16 KB window, all halt/refresh mixes, both filters
    for (int f = 0; f < 2; f++) begin
      page_en = f[0];
      for (int i = 0; i < 160; i++) begin
        for (int k = 0; k < 4; k++) begin
          host_cycle(k[0], k[1], 14'((i * 103 + k * 7) % 16384), 1'b0);
        end
      end
    end

    // corners of both pages
    page_en = 1'b1;
    host_cycle(1'b1, 1'b0, 14'h0000, 1'b0);
    host_cycle(1'b1, 1'b0, 14'h1fff, 1'b0);
    host_cycle(1'b1, 1'b0, 14'h2000, 1'b0);
    host_cycle(1'b1, 1'b0, 14'h3fff, 1'b0);
    page_en = 1'b0;
    host_cycle(1'b1, 1'b0, 14'h0000, 1'b0);
    host_cycle(1'b1, 1'b0, 14'h1fff, 1'b0);

    // R8: halt/refresh flipped everywhere but the sample edge
    for (int k = 0; k < 4; k++) begin
      host_cycle(k[0], k[1], 14'h2a55 + 14'(k), 1'b1);
    end
    page_en = 1'b1;
    host_cycle(1'b1, 1'b0, 14'h3c3c, 1'b1);
    host_cycle(1'b0, 1'b0, 14'h3c3d, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule